// File: doc/BRIEF.md
# PWM Slice with Fractional Clock Divider

This block produces two pulse-width-modulated outputs from one shared up-counter. The counter runs from zero up to a programmable wrap value and then restarts, so the period is the wrap value plus one tick. Each output has its own compare level. An output is high while the counter is below its level, so a level of zero gives a constant low and a level of wrap-plus-one gives a constant high. The counter does not advance on every clock. A clock-enable divider sets the tick rate, and that divider has an 8-bit integer part and a 4-bit fraction in sixteenths.

Software writes the configuration through a simple write port. New wrap and compare values go into staging registers first. They reach the counter logic only when a period ends, so a period is never cut short or stretched by a write. The slice also holds a combinational converter. It maps a 16-bit normalised duty request (0 to 65535) to a compare level for the staged wrap value, rounding to the nearest level. A full-scale request maps exactly to wrap-plus-one.

Top module: `pwm_slice`

## Requirements
- R1: With the wrap value W (register address 1) and the divider at 1.0, one period lasts W+1 clocks. `wrapPulse` is high for exactly one clock, in the last clock of each period.
- R2: Compare levels are written at address 2 (channel A) and address 3 (channel B). A channel is high in exactly min(level, W+1) clocks of each period. A level of 0 keeps the channel low for the whole period.
- R3: A compare level of W+1 or above keeps the channel high for every clock of the period.
- R4: The divider is written at address 4. Bits [11:4] hold the integer part I and bits [3:0] hold the fraction F. One tick lasts (16*I+F)/16 clocks on average: the fraction accumulates on each tick, and each carry adds one clock. I=0 behaves as I=1.
- R5: A wrap or compare write made while running does not change the period in progress. It takes effect from the next period.
- R6: Bit 0 of address 0 enables the slice. While it is clear, the counter stays at 0, both outputs are low and `wrapPulse` stays low. The new configuration applies from the first period after enabling.
- R7: A wrap value above 65534 that is written is stored as 65534.
- R8: When `dutyReq` is 65535, `dutyLevel` equals the staged wrap value plus one.
- R9: For any other `dutyReq` d, `dutyLevel` equals floor((d*W + 32767) / 65534), where W is the staged wrap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 wrap, 2 level A, 3 level B, 4 divider) |
| wrData | input | 16 | Register write data |
| dutyReq | input | 16 | Normalised duty request for the converter |
| dutyLevel | output | 16 | Compare level computed for the staged wrap value |
| pwmA | output | 1 | Channel A output |
| pwmB | output | 1 | Channel B output |
| wrapPulse | output | 1 | One-clock pulse on the tick at which the counter wraps |

## Verification
The assertions check the following on every cycle:
- the counter never exceeds the active wrap value;
- a wrap is always followed by a zero count;
- the active values hold steady between wraps;
- the staged wrap value never exceeds its limit;
- the slice stays quiet while disabled;
- a zero level and a level above the wrap value force their outputs.

Only the bench scenarios can show the rest: the exact period lengths under integer and fractional division, the per-period high counts, the deferral of a mid-period write to the next period, and the rounding of the converter across random requests and wrap values.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Register addresses of the write port
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_WRAP  = 1;
  localparam int unsigned ADDR_LVL_A = 2;
  localparam int unsigned ADDR_LVL_B = 3;
  localparam int unsigned ADDR_DIV   = 4;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic enable;
    logic tick;
  } slice_strb_t;
endpackage

// File: rtl/pwm_duty_conv.sv
module pwm_duty_conv #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] dutyReq,
  input  logic [CNT_W-1:0] wrapVal,
  output logic [CNT_W-1:0] dutyLevel
);
  localparam logic [CNT_W-1:0]   FULL  = {CNT_W{1'b1}};
  localparam logic [2*CNT_W-1:0] DENOM = (2*CNT_W)'(FULL) - 1'b1;
  localparam logic [2*CNT_W-1:0] HALF  = DENOM >> 1;

  logic [2*CNT_W-1:0] scaled;
  logic [2*CNT_W-1:0] quot;
  logic [CNT_W:0]     wrapPlusOne;

  always_comb begin
    scaled      = (2*CNT_W)'(dutyReq) * (2*CNT_W)'(wrapVal) + HALF;
    quot        = scaled / DENOM;
    wrapPlusOne = (CNT_W+1)'(wrapVal) + 1'b1;
    if (dutyReq == FULL) begin
      dutyLevel = wrapPlusOne[CNT_W] ? FULL : wrapPlusOne[CNT_W-1:0];
    end else begin
      dutyLevel = quot[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [CNT_W-1:0]       wrData,
  output slice_strb_t            strb,
  output logic [CNT_W-1:0]       stageWrap,
  output logic [1:0][CNT_W-1:0]  stageLevel
);
  localparam logic [CNT_W-1:0] WRAP_MAX = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam int unsigned      DCNT_W   = INT_W + 1;

  logic               enableQ;
  logic [INT_W-1:0]   divIntQ;
  logic [FRAC_W-1:0]  divFracQ;
  logic [DCNT_W-1:0]  divCnt;
  logic [FRAC_W-1:0]  phaseQ;
  logic               extraQ;
  logic [DCNT_W-1:0]  intEff;
  logic [DCNT_W-1:0]  limit;
  logic [FRAC_W:0]    phaseSum;
  logic               tick;

  // Register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      stageWrap  <= WRAP_MAX;
      stageLevel <= '0;
      divIntQ    <= INT_W'(1);
      divFracQ   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(ADDR_CTRL):  enableQ <= wrData[0];
        ADDR_W'(ADDR_WRAP):  stageWrap <= (wrData > WRAP_MAX) ? WRAP_MAX : wrData;
        ADDR_W'(ADDR_LVL_A): stageLevel[0] <= wrData;
        ADDR_W'(ADDR_LVL_B): stageLevel[1] <= wrData;
        ADDR_W'(ADDR_DIV): begin
          divIntQ  <= wrData[FRAC_W +: INT_W];
          divFracQ <= wrData[FRAC_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Fractional clock-enable divider
  always_comb begin
    intEff   = (divIntQ == '0) ? DCNT_W'(1) : DCNT_W'(divIntQ);
    limit    = intEff + DCNT_W'(extraQ);
    tick     = enableQ && (divCnt >= limit);
    phaseSum = (FRAC_W+1)'(phaseQ) + (FRAC_W+1)'(divFracQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enableQ) begin
      divCnt <= DCNT_W'(1);
      phaseQ <= '0;
      extraQ <= 1'b0;
    end else if (tick) begin
      divCnt <= DCNT_W'(1);
      phaseQ <= phaseSum[FRAC_W-1:0];
      extraQ <= phaseSum[FRAC_W];
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign strb.enable = enableQ;
  assign strb.tick   = tick;
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NCH   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slice_strb_t              strb,
  input  logic [CNT_W-1:0]         stageWrap,
  input  logic [NCH-1:0][CNT_W-1:0] stageLevel,
  output logic [CNT_W-1:0]         count,
  output logic [CNT_W-1:0]         activeWrap,
  output logic [NCH-1:0][CNT_W-1:0] activeLevel,
  output logic [NCH-1:0]           pwmOut,
  output logic                     wrapPulse
);
  logic atWrap;

  assign atWrap    = (count == activeWrap);
  assign wrapPulse = strb.tick && atWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      activeWrap  <= '0;
      activeLevel <= '0;
    end else if (!strb.enable) begin
      count       <= '0;
      activeWrap  <= stageWrap;
      activeLevel <= stageLevel;
    end else if (strb.tick) begin
      if (atWrap) begin
        count       <= '0;
        activeWrap  <= stageWrap;
        activeLevel <= stageLevel;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign pwmOut[ch] = strb.enable && (count < activeLevel[ch]);
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  dutyReq,
  output logic [CNT_W-1:0]  dutyLevel,
  output logic              pwmA,
  output logic              pwmB,
  output logic              wrapPulse
);
  slice_strb_t             strb;
  logic [CNT_W-1:0]        stageWrap;
  logic [1:0][CNT_W-1:0]   stageLevel;
  logic [CNT_W-1:0]        count;
  logic [CNT_W-1:0]        activeWrap;
  logic [1:0][CNT_W-1:0]   activeLevel;
  logic [1:0]              pwmOut;

  pwm_ctrl #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .stageWrap(stageWrap), .stageLevel(stageLevel)
  );

  pwm_dp #(.CNT_W(CNT_W), .NCH(2)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stageWrap(stageWrap),
    .stageLevel(stageLevel), .count(count), .activeWrap(activeWrap),
    .activeLevel(activeLevel), .pwmOut(pwmOut), .wrapPulse(wrapPulse)
  );

  pwm_duty_conv #(.CNT_W(CNT_W)) i_conv (
    .dutyReq(dutyReq), .wrapVal(stageWrap), .dutyLevel(dutyLevel)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] activeWrap,
  input logic [CNT_W-1:0] activeLvlA,
  input logic [CNT_W-1:0] stageWrap,
  input logic [CNT_W-1:0] dutyReq,
  input logic [CNT_W-1:0] dutyLevel,
  input logic             pwmA,
  input logic             pwmB,
  input logic             wrapPulse
);
  localparam logic [CNT_W-1:0] WRAP_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> count <= activeWrap); // R1
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> count == '0); // R1
  AST_ZERO_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    activeLvlA == '0 |-> !pwmA); // R2
  AST_FULL_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && activeLvlA > activeWrap) |-> pwmA); // R3
  AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> tick); // R4
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !wrapPulse) |=> ($stable(activeWrap) && $stable(activeLvlA))); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!pwmA && !pwmB && !wrapPulse)); // R6
  AST_WRAP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    stageWrap <= WRAP_MAX); // R7
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    dutyReq == {CNT_W{1'b1}} |-> dutyLevel == stageWrap + 1'b1); // R8
endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .enable(strb.enable), .tick(strb.tick),
  .count(count), .activeWrap(activeWrap), .activeLvlA(activeLevel[0]),
  .stageWrap(stageWrap), .dutyReq(dutyReq), .dutyLevel(dutyLevel),
  .pwmA(pwmA), .pwmB(pwmB), .wrapPulse(wrapPulse)
);

// File: tb/test_pwm_slice.sv
module test_pwm_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] dutyReq = '0;
  logic [15:0] dutyLevel;
  logic        pwmA, pwmB, wrapPulse;

  int tests = 0;
  int fails = 0;
  int expWrap = 65534;

  pwm_slice i_pwm_slice (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dutyReq(dutyReq), .dutyLevel(dutyLevel), .pwmA(pwmA), .pwmB(pwmB),
    .wrapPulse(wrapPulse)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int expLevel(int d, int w);
    longint p;
    if (d == 65535) return (w + 1 > 65535) ? 65535 : w + 1;
    p = longint'(d) * longint'(w) + 32767;
    return int'(p / 65534);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
    if (addr == 1) expWrap = (data > 65534) ? 65534 : data;
  endtask

  task automatic waitWrap();
    int n = 0;
    while (!wrapPulse && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check(1'b0, "wrap timeout", n, 0);
  endtask

  // Starting at a negedge where wrapPulse is seen, count one full period
  task automatic measure(output int clocks, output int hiA, output int hiB);
    clocks = 0; hiA = 0; hiB = 0;
    do begin
      @(negedge clk);
      clocks++;
      hiA += int'(pwmA);
      hiB += int'(pwmB);
    end while (!wrapPulse && clocks < 5000);
  endtask

  task automatic runPeriod(output int clocks, output int hiA, output int hiB);
    @(negedge clk);
    waitWrap();
    measure(clocks, hiA, hiB);
  endtask

  task automatic restart(input int wrapV, input int lvlA, input int lvlB, input int divV);
    writeReg(0, 0);
    writeReg(1, wrapV);
    writeReg(2, lvlA);
    writeReg(3, lvlB);
    writeReg(4, divV);
    writeReg(0, 1);
  endtask

  initial begin
    int clocks, hiA, hiB;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state: disabled and quiet
    check(!pwmA && !pwmB && !wrapPulse, "R6 reset outputs", {pwmA, pwmB, wrapPulse}, 0);
    dutyReq = 16'hFFFF;
    #1;
    check(dutyLevel == 16'hFFFF, "R8 reset full scale", dutyLevel, 65535);

    // Integer divide by one: period and levels
    restart(9, 3, 10, 16'h0010);
    runPeriod(clocks, hiA, hiB);
    check(clocks == 10, "R1 period W=9", clocks, 10);
    check(hiA == 3, "R2 level 3 high count", hiA, 3);
    check(hiB == 10, "R3 level W+1 always high", hiB, 10);
    writeReg(2, 0);
    writeReg(3, 15);
    runPeriod(clocks, hiA, hiB);
    check(hiA == 0, "R2 level 0 always low", hiA, 0);
    check(hiB == 10, "R3 level above W+1 high", hiB, 10);

    // Deferred update of the wrap value
    writeReg(2, 2);
    @(negedge clk);
    waitWrap();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd1; wrData = 16'd4;
    @(negedge clk);
    wrEn = 1'b0; expWrap = 4;
    begin
      int c = 2;
      while (!wrapPulse && c < 5000) begin @(negedge clk); c++; end
      check(c == 10, "R5 period in progress keeps old wrap", c, 10);
    end
    measure(clocks, hiA, hiB);
    check(clocks == 5, "R5 new wrap from next period", clocks, 5);
    check(hiA == 2, "R2 level 2 with W=4", hiA, 2);

    // Fractional and integer division
    restart(3, 1, 1, (2 << 4) | 8);
    runPeriod(clocks, hiA, hiB);
    runPeriod(clocks, hiA, hiB);
    check(clocks == 10, "R4 divide 2.5 W=3", clocks, 10);
    restart(7, 1, 1, (1 << 4) | 4);
    runPeriod(clocks, hiA, hiB);
    runPeriod(clocks, hiA, hiB);
    check(clocks == 10, "R4 divide 1.25 W=7", clocks, 10);
    restart(4, 1, 1, 3 << 4);
    runPeriod(clocks, hiA, hiB);
    check(clocks == 15, "R4 divide 3 W=4", clocks, 15);
    check(hiA == 3, "R4 level 1 lasts one tick", hiA, 3);
    restart(5, 1, 1, 0);
    runPeriod(clocks, hiA, hiB);
    check(clocks == 6, "R4 integer 0 acts as 1", clocks, 6);

    // Disable: quiet for a stretch
    restart(3, 4, 4, 16'h0010);
    writeReg(0, 0);
    begin
      int loud = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (pwmA || pwmB || wrapPulse) loud++;
      end
      check(loud == 0, "R6 disabled outputs low", loud, 0);
    end

    // Wrap clamp seen through the converter
    writeReg(1, 65535);
    dutyReq = 16'd32768;
    #1;
    check(dutyLevel == 16'(expLevel(32768, 65534)), "R7 wrap clamped to 65534",
          dutyLevel, expLevel(32768, 65534));

    // Converter corners
    writeReg(1, 0);
    dutyReq = 16'hFFFF; #1;
    check(dutyLevel == 16'd1, "R8 full scale with W=0", dutyLevel, 1);
    dutyReq = 16'hFFFE; #1;
    check(dutyLevel == 16'(expLevel(65534, 0)), "R9 near full with W=0", dutyLevel, expLevel(65534, 0));
    writeReg(1, 254);
    dutyReq = 16'hFFFE; #1;
    check(dutyLevel == 16'(expLevel(65534, 254)), "R9 65534 with W=254", dutyLevel, expLevel(65534, 254));
    dutyReq = 16'hFFFF; #1;
    check(dutyLevel == 16'd255, "R8 full scale W=254", dutyLevel, 255);

    // Random converter requests
    for (int k = 0; k < 150; k++) begin
      int w = int'($urandom % 65536);
      int d = (k % 10 == 0) ? 65535 : int'($urandom % 65536);
      writeReg(1, w);
      dutyReq = 16'(d);
      #1;
      if (d == 65535)
        check(dutyLevel == 16'(expLevel(d, expWrap)), "R8 random full scale", dutyLevel, expLevel(d, expWrap));
      else
        check(dutyLevel == 16'(expLevel(d, expWrap)), "R9 random rounding", dutyLevel, expLevel(d, expWrap));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule